// File: doc/BRIEF.md
# Hamming SEC-DED Codec for Byte Data

This block protects an 8-bit data word with a single-error-correcting, double-error-detecting Hamming code. The encoder side is purely combinational. It turns a data byte into a 13-bit codeword: four even-parity check bits are interleaved with the data at power-of-two positions, and one overall parity bit is appended on top.

The decoder side takes a received 13-bit word and recomputes the four group parities, which give a syndrome. It also recomputes the overall parity. From these two results it classifies the word as clean, single-error (corrected) or uncorrectable. It returns the corrected byte, the syndrome and two flags. A parameter selects whether the decoder results pass through one output register stage (the default) or leave the block combinationally.

A typical use puts the encoder on the write path of a storage element and the decoder on its read path. The single-error flag then marks words that were repaired on the fly, and the double-error flag marks words that the decoder could not repair.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit `code_o[p-1]` holds code position p, for p from 1 to 13. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit, in that order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. Position 13 (`code_o[12]`) is chosen so that all 13 bits XOR to zero.
- R2: The check bit at position 2^k makes the XOR of every position among 1 to 12 whose index has bit k set equal to zero. This is even parity, and the group includes the check bit itself.
- R3: A received word equal to a valid codeword yields syndrome 0, both flags low, and the original data.
- R4: A received word with exactly one flipped bit at a position p between 1 and 12 yields syndrome p, the single-error flag high, the double-error flag low, and the original data.
- R5: A received word whose only flipped bit is position 13 yields syndrome 0, the single-error flag high, and unchanged data.
- R6: A received word with exactly two flipped bits yields the double-error flag high and the single-error flag low. The syndrome is the XOR of the two positions, with position 13 counting as 0. The data output holds the received data positions uncorrected.
- R7: A syndrome above 12 together with failing overall parity is uncorrectable. The double-error flag is high, the single-error flag is low, and the data is passed through uncorrected.
- R8: The single-error flag and the double-error flag are never high together.
- R9: With `OUT_REG`=1 (the default), the decoder outputs change only on the clock edge after the received word is applied, and they read zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Data byte to encode |
| code_o | output | 13 | Encoded codeword, bit p-1 is position p |
| code_i | input | 13 | Received codeword to decode |
| data_o | output | 8 | Corrected (or passed-through) data byte |
| syndrome_o | output | 4 | Recomputed syndrome |
| single_err_o | output | 1 | Single error found and corrected |
| double_err_o | output | 1 | Uncorrectable error found |

## Verification
The assertions relate the registered outputs to the raw data positions of the word received one cycle earlier. They therefore assume that `code_i` is stable across each sampling edge and that reset has been released for at least one cycle. The bench changes `code_i` only on falling edges and compares on the following falling edge.

The patterns applied are clean words, every single and double flip, and every triple flip whose syndrome exceeds 12. Triple flips with a smaller syndrome would be miscorrected by design, so they are deliberately left out of the stimulus.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int unsigned DATA_W = 8;

  function automatic int unsigned calc_chk_w(int unsigned dw);
    int unsigned p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  localparam int unsigned CHK_W = calc_chk_w(DATA_W);
  localparam int unsigned HAM_W = DATA_W + CHK_W;
  localparam int unsigned CW_W  = HAM_W + 1;

  function automatic bit is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // position (1-based) of data bit j
  function automatic int unsigned data_pos(int unsigned j);
    int unsigned pos;
    int unsigned cnt;
    pos = 0;
    cnt = 0;
    for (int unsigned p = 1; p <= HAM_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == j) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  // vector bit b stands for position b+1
  function automatic logic [HAM_W-1:0] cover_mask(int unsigned k);
    logic [HAM_W-1:0] m;
    m = '0;
    for (int unsigned p = 1; p <= HAM_W; p++)
      if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o
);
  logic [HAM_W-1:0] dvec;
  logic [HAM_W-1:0] cvec;
  logic [HAM_W-1:0] ham;

  for (genvar p = 1; p <= HAM_W; p++) begin : g_pos
    if (is_pow2(p)) begin : g_chk_slot
      assign dvec[p-1] = 1'b0;
    end else begin : g_dat_slot
      assign dvec[p-1] = 1'b0 | data_i[data_pos_idx(p)];
    end
  end

  function automatic int unsigned data_pos_idx(int unsigned p);
    int unsigned idx;
    idx = 0;
    for (int unsigned j = 0; j < DATA_W; j++)
      if (data_pos(j) == p) idx = j;
    return idx;
  endfunction

  for (genvar p = 1; p <= HAM_W; p++) begin : g_cvec
    if (is_pow2(p)) begin : g_chk
      assign cvec[p-1] = ^(dvec & cover_mask($clog2(p)));
    end else begin : g_zero
      assign cvec[p-1] = 1'b0;
    end
  end

  assign ham    = dvec | cvec;
  assign code_o = {^ham, ham};
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   code_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic              par_fail_o,
  output logic [DATA_W-1:0] raw_data_o
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn_o[k] = ^(code_i[HAM_W-1:0] & cover_mask(k));
  end

  assign par_fail_o = ^code_i;

  for (genvar j = 0; j < DATA_W; j++) begin : g_raw
    assign raw_data_o[j] = code_i[data_pos(j)-1];
  end
endmodule

// File: rtl/secded_correct.sv
module secded_correct
  import secded_pkg::*;
(
  input  logic [HAM_W-1:0]  ham_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              par_fail_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic             syn_nz;
  logic             in_range;
  logic             do_fix;
  logic [HAM_W-1:0] flip;
  logic [HAM_W-1:0] fixed;

  assign syn_nz   = |syn_i;
  assign in_range = syn_nz && (int'(syn_i) <= int'(HAM_W));
  assign do_fix   = par_fail_i && in_range;
  assign flip     = do_fix ? (HAM_W'(1) << (syn_i - 1'b1)) : '0;
  assign fixed    = ham_i ^ flip;

  // odd weight + valid pointer (or zero syndrome) -> single; else any nonzero syndrome is fatal
  assign single_o = par_fail_i && (!syn_nz || in_range);
  assign double_o = syn_nz && !do_fix;

  for (genvar j = 0; j < DATA_W; j++) begin : g_out
    assign data_o[j] = fixed[data_pos(j)-1];
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o,
  input  logic [CW_W-1:0]   code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic              single_err_o,
  output logic              double_err_o
);
  logic [CHK_W-1:0]  syn;
  logic              par_fail;
  logic [DATA_W-1:0] raw_data;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_double;

  secded_enc u_enc (
    .data_i (data_i),
    .code_o (code_o)
  );

  secded_syndrome u_syn (
    .code_i     (code_i),
    .syn_o      (syn),
    .par_fail_o (par_fail),
    .raw_data_o (raw_data)
  );

  secded_correct u_cor (
    .ham_i      (code_i[HAM_W-1:0]),
    .syn_i      (syn),
    .par_fail_i (par_fail),
    .data_o     (dec_data),
    .single_o   (dec_single),
    .double_o   (dec_double)
  );

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o       <= '0;
        syndrome_o   <= '0;
        single_err_o <= 1'b0;
        double_err_o <= 1'b0;
      end else begin
        data_o       <= dec_data;
        syndrome_o   <= syn;
        single_err_o <= dec_single;
        double_err_o <= dec_double;
      end
    end

    a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(single_err_o && double_err_o));

    a_r4_single_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (single_err_o && syndrome_o != '0) |-> (int'(syndrome_o) <= int'(HAM_W)));

    a_r5_parity_only_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && single_err_o && syndrome_o == '0) |-> (data_o == $past(raw_data)));

    a_r6_double_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && double_err_o) |-> (data_o == $past(raw_data)));

    a_r3_clean_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !single_err_o && !double_err_o) |->
        (syndrome_o == '0 && data_o == $past(raw_data)));
  end else begin : g_comb
    assign data_o       = dec_data;
    assign syndrome_o   = syn;
    assign single_err_o = dec_single;
    assign double_err_o = dec_double;
  end
endmodule

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
module tb_secded_codec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic [12:0] code_o;
  logic [12:0] code_i = '0;
  logic [7:0]  data_o;
  logic [3:0]  syndrome_o;
  logic        single_err_o;
  logic        double_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  secded_codec dut (.*);

  function automatic bit pow2(int v);
    return v == 1 || v == 2 || v == 4 || v == 8;
  endfunction

  // reference encoder: data into non-power-of-two slots, parity by counting
  function automatic logic [12:0] ref_enc(logic [7:0] d);
    logic [12:0] cw;
    int n;
    cw = '0;
    n = 0;
    for (int p = 1; p <= 12; p++)
      if (!pow2(p)) begin cw[p-1] = d[n]; n++; end
    for (int c = 1; c <= 8; c = c * 2) begin
      int ones;
      ones = 0;
      for (int p = 1; p <= 12; p++)
        if ((p & c) != 0 && cw[p-1]) ones++;
      cw[c-1] = (ones % 2) == 1;
    end
    begin
      int ones;
      ones = 0;
      for (int p = 0; p < 12; p++) if (cw[p]) ones++;
      cw[12] = (ones % 2) == 1;
    end
    return cw;
  endfunction

  function automatic logic [7:0] ref_extract(logic [12:0] cw);
    logic [7:0] d;
    int n;
    n = 0;
    d = '0;
    for (int p = 1; p <= 12; p++)
      if (!pow2(p)) begin d[n] = cw[p-1]; n++; end
    return d;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(string req, logic [12:0] cw, logic [7:0] ed, logic [3:0] es,
                       logic esg, logic edb);
    code_i = cw;
    @(negedge clk_i);
    chk(req, {24'b0, data_o}, {24'b0, ed}, "data");
    chk(req, {28'b0, syndrome_o}, {28'b0, es}, "syndrome");
    chk(req, {31'b0, single_err_o}, {31'b0, esg}, "single flag");
    chk(req, {31'b0, double_err_o}, {31'b0, edb}, "double flag");
    chk("R8", {31'b0, single_err_o & double_err_o}, 32'd0, "flag overlap");
  endtask

  task automatic run_word(logic [7:0] d);
    logic [12:0] cw;
    cw = ref_enc(d);
    data_i = d;
    #0.5;
    chk("R1", {19'b0, code_o}, {19'b0, cw}, "codeword");
    chk("R2", {31'b0, ^code_o}, 32'd0, "overall even parity");
    apply("R3", cw, d, 4'd0, 1'b0, 1'b0);
    for (int i = 1; i <= 13; i++) begin
      logic [12:0] e;
      e = cw ^ (13'd1 << (i - 1));
      if (i == 13) apply("R5", e, d, 4'd0, 1'b1, 1'b0);
      else         apply("R4", e, d, 4'(i), 1'b1, 1'b0);
    end
    for (int i = 1; i <= 13; i++)
      for (int j = i + 1; j <= 13; j++) begin
        logic [12:0] e;
        int s;
        e = cw ^ (13'd1 << (i - 1)) ^ (13'd1 << (j - 1));
        s = (i == 13 ? 0 : i) ^ (j == 13 ? 0 : j);
        apply("R6", e, ref_extract(e), 4'(s), 1'b0, 1'b1);
      end
  endtask

  task automatic run_triples(logic [7:0] d);
    logic [12:0] cw;
    cw = ref_enc(d);
    for (int i = 1; i <= 12; i++)
      for (int j = i + 1; j <= 12; j++)
        for (int k = j + 1; k <= 12; k++)
          if ((i ^ j ^ k) > 12) begin
            logic [12:0] e;
            e = cw ^ (13'd1 << (i - 1)) ^ (13'd1 << (j - 1)) ^ (13'd1 << (k - 1));
            apply("R7", e, ref_extract(e), 4'(i ^ j ^ k), 1'b0, 1'b1);
          end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    code_i = 13'h1fff;
    repeat (3) @(negedge clk_i);
    chk("R9", {24'b0, data_o}, 32'd0, "reset data");
    chk("R9", {28'b0, syndrome_o}, 32'd0, "reset syndrome");
    chk("R9", {30'b0, single_err_o, double_err_o}, 32'd0, "reset flags");
    rst_ni = 1'b1;
    code_i = ref_enc(8'h00);
    @(negedge clk_i);
    // R9 latency: apply a single flip, outputs hold until the next edge
    code_i = ref_enc(8'h00) ^ 13'h0004;
    #1;
    chk("R9", {31'b0, single_err_o}, 32'd0, "flag before edge");
    @(negedge clk_i);
    chk("R9", {28'b0, syndrome_o}, 32'd3, "syndrome after edge");
    foreach (pat[n]) run_word(pat[n]);
    for (int n = 0; n < 10; n++) run_word(8'($urandom));
    run_triples(8'hc4);
    run_triples(8'h3b);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [7:0] pat [6] = '{8'h00, 8'hff, 8'haa, 8'h55, 8'h01, 8'h80};
endmodule